// File: doc/BRIEF.md
# CPU System Register File

This block holds the control and status state of a 32-bit processor core: the status word, two saved program-counter and saved-status pairs used on exception entry, an exception-cause word, an address-trap register, a cache-control bit and two scratch registers. The core reaches it through a 5-bit index. There is one combinational read port and one write port.

Every write goes through a transform that belongs to the addressed register. Depending on the register, the transform masks reserved bits, clears the low address bit, forces a constant, or takes the absolute value of the data. The transformed value appears on `wr_stored` in the same cycle. The core uses it as the result of its move-to-system-register operation, and it is what the register holds after the next clock edge. A debug-mode input unlocks writes to the cause register and turns off the absolute-value rule on index 31. The status word also drives a dedicated output, so the core can see flags and the interrupt level without using the read port.

Top module: `sysreg_file`

## Requirements
- R1: After reset, index 5 (status word) reads 0x00008000 and `status_word` equals 0x00008000. Indices 0, 1, 2, 3, 4, 24, 25, 29 and 31 read 0.
- R2: A write to index 5, index 1 or index 3 stores the data ANDed with 0x000FF3FF.
- R3: A write to index 0, index 2 or index 25 stores the data with bit 0 cleared.
- R4: A write to index 4 (cause register: fatal code in [31:16], interrupt code in [15:0]) stores the data only while `dbg_mode` is 1. Otherwise the register keeps its contents, and `wr_stored` shows those contents.
- R5: Index 6 always reads 0x00005346, index 7 always reads 0x000000E0 and index 30 always reads 0x00000004. A write to any of them leaves the read value unchanged, and `wr_stored` shows the constant.
- R6: Index 29 stores all 32 bits of written data unchanged.
- R7: With `dbg_mode` 0, a write to index 31 of a value that is negative as a signed number stores its two's-complement negation; other values are stored unchanged. With `dbg_mode` 1, the data is stored unchanged.
- R8: A write to index 24 keeps only bit 1 and stores zero in every other bit.
- R9: Any index not named above reads 0, and `wr_stored` is 0 for it.
- R10: `wr_stored` is combinational from `wr_idx`, `wr_data` and `dbg_mode`. It equals the value read back from the written index in the cycle after the write.
- R11: `status_word` always equals the contents of the status word.
- R12: While `wr_en` is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Debug mode: unlocks cause writes and turns off the absolute-value rule |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data before transform |
| wr_stored | output | 32 | Value that a write to `wr_idx` stores |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Read data |
| status_word | output | 32 | Current status word |

## Verification
The bench exercises the masks with all-ones patterns and with mixed patterns, so that a mask with a wrong hex digit keeps the reserved bits 10 and 11 or drops part of the interrupt level. It writes the cause register with debug mode off both before and after a debug write: a design that ignored `dbg_mode` would pick up the junk data, and one that returned the written data on `wr_stored` would report a store that never took place. On index 31 it checks a negative value, a positive value and a debug-mode negative value, which catches a missing sign test or a debug bypass that has no effect. Writes to constant and unmapped indices, and a write with the enable low, show up as changes on the read port if the design decodes or gates them wrongly.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  // register indices (fixed by the core's instruction decode)
  localparam logic [IDX_W-1:0] SR_EPC   = 5'd0;
  localparam logic [IDX_W-1:0] SR_EPSW  = 5'd1;
  localparam logic [IDX_W-1:0] SR_FPC   = 5'd2;
  localparam logic [IDX_W-1:0] SR_FPSW  = 5'd3;
  localparam logic [IDX_W-1:0] SR_CAUSE = 5'd4;
  localparam logic [IDX_W-1:0] SR_STAT  = 5'd5;
  localparam logic [IDX_W-1:0] SR_PID   = 5'd6;
  localparam logic [IDX_W-1:0] SR_TCTL  = 5'd7;
  localparam logic [IDX_W-1:0] SR_CACHE = 5'd24;
  localparam logic [IDX_W-1:0] SR_TRAP  = 5'd25;
  localparam logic [IDX_W-1:0] SR_SCR_A = 5'd29;
  localparam logic [IDX_W-1:0] SR_FIX   = 5'd30;
  localparam logic [IDX_W-1:0] SR_SCR_B = 5'd31;

  localparam logic [DATA_W-1:0] STAT_MASK = 32'h000F_F3FF;
  localparam logic [DATA_W-1:0] STAT_RST  = 32'h0000_8000;
  localparam logic [DATA_W-1:0] PID_VAL   = 32'h0000_5346;
  localparam logic [DATA_W-1:0] TCTL_VAL  = 32'h0000_00E0;
  localparam logic [DATA_W-1:0] FIX_VAL   = 32'h0000_0004;
  localparam int                CACHE_BIT = 1;

  // storage slots, one per writable register
  localparam int NSLOT   = 10;
  localparam int SL_STAT = 5;
  localparam logic [NSLOT-1:0][IDX_W-1:0] SLOT_IDX = {
    SR_SCR_B, SR_SCR_A, SR_TRAP, SR_CACHE, SR_STAT,
    SR_CAUSE, SR_FPSW, SR_FPC, SR_EPSW, SR_EPC};
  localparam int SL_CAUSE = 4;

  typedef logic [NSLOT-1:0][DATA_W-1:0] slot_vec_t;
endpackage

// File: rtl/sysreg_cell.sv
module sysreg_cell #(
  parameter int            W   = 32,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (en) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nx;
  end
endmodule

// File: rtl/sysreg_wxform.sv
module sysreg_wxform
  import sysreg_pkg::*;
(
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_mode,
  input  logic [DATA_W-1:0] cur_cause,
  output logic [DATA_W-1:0] stored
);
  logic [DATA_W-1:0] magnitude;

  always_comb begin
    magnitude = wr_data;
    if (!dbg_mode && wr_data[DATA_W-1]) magnitude = ~wr_data + 1'b1;
  end

  always_comb begin
    stored = '0;
    case (wr_idx)
      SR_EPC, SR_FPC, SR_TRAP:   stored = {wr_data[DATA_W-1:1], 1'b0};
      SR_EPSW, SR_FPSW, SR_STAT: stored = wr_data & STAT_MASK;
      SR_CAUSE:                  stored = dbg_mode ? wr_data : cur_cause;
      SR_PID:                    stored = PID_VAL;
      SR_TCTL:                   stored = TCTL_VAL;
      SR_FIX:                    stored = FIX_VAL;
      SR_CACHE:                  stored[CACHE_BIT] = wr_data[CACHE_BIT];
      SR_SCR_A:                  stored = wr_data;
      SR_SCR_B:                  stored = magnitude;
      default:                   stored = '0;
    endcase
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  output slot_vec_t         slots
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_V = (g == SL_STAT) ? STAT_RST : '0;
    logic hit;
    assign hit = wr_en && (wr_idx == SLOT_IDX[g]);
    sysreg_cell #(.W(DATA_W), .RST(RST_V)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (hit),
      .d    (wr_val),
      .q    (slots[g])
    );
  end
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import sysreg_pkg::*;
(
  input  logic [IDX_W-1:0]  rd_idx,
  input  slot_vec_t         slots,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_idx == SLOT_IDX[s]) rd_data = slots[s];
    end
    case (rd_idx)
      SR_PID:  rd_data = PID_VAL;
      SR_TCTL: rd_data = TCTL_VAL;
      SR_FIX:  rd_data = FIX_VAL;
      default: ;
    endcase
  end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_stored,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status_word
);
  slot_vec_t slots;

  sysreg_wxform u_wx (
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .dbg_mode (dbg_mode),
    .cur_cause(slots[SL_CAUSE]),
    .stored   (wr_stored)
  );

  sysreg_store u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_val(wr_stored),
    .slots (slots)
  );

  sysreg_rdmux u_rd (
    .rd_idx (rd_idx),
    .slots  (slots),
    .rd_data(rd_data)
  );

  assign status_word = slots[SL_STAT];
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk
  import sysreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_mode,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] wr_stored,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] status_word
);
  AST_STAT_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~STAT_MASK) == '0); // R2

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == SR_EPC || rd_idx == SR_FPC || rd_idx == SR_TRAP) |-> !rd_data[0]); // R3

  AST_CAUSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == SR_CAUSE && !dbg_mode && rd_idx == SR_CAUSE) |-> wr_stored == rd_data); // R4

  AST_PID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx == SR_PID |-> rd_data == PID_VAL); // R5

  AST_SCRB_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == SR_SCR_B && !dbg_mode) |-> (!wr_stored[DATA_W-1] || wr_data == 32'h8000_0000)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx inside {[5'd8:5'd23], 5'd26, 5'd27, 5'd28}) |-> rd_data == '0); // R9

  AST_STORED_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx) |=>
      (rd_idx != $past(rd_idx)) || (rd_data == $past(wr_stored))); // R10

  AST_IDLE_HOLDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_word)); // R12
endmodule

bind sysreg_file sysreg_chk u_chk (.*);

// File: tb/tb_sysreg_file.sv
module tb_sysreg_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_mode;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [31:0] wr_stored;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic [31:0] status_word;

  int total = 0;
  int bad   = 0;
  int ticks = 0;
  bit done  = 1'b0;

  typedef struct {
    int          sel;   // 0 rd_data, 1 wr_stored, 2 status_word
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  sysreg_file dut (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_stored(wr_stored),
    .rd_idx(rd_idx), .rd_data(rd_data), .status_word(status_word));

  // monitor: compare every queued expectation away from the clock edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = (it.sel == 0) ? rd_data : (it.sel == 1) ? wr_stored : status_word;
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s: out=%0d actual=%h expected=%h", it.tag, it.sel, act, it.val);
      end
    end
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=5000", ticks);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_out(int sel, logic [31:0] val, string tag);
    item_t it;
    it.sel = sel; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(bit we, logic [4:0] wi, logic [31:0] wd, bit dbg, logic [4:0] ri);
    @(posedge clk); #1;
    wr_en = we; wr_idx = wi; wr_data = wd; dbg_mode = dbg; rd_idx = ri;
  endtask

  // write, check the same-cycle stored value, then read it back
  task automatic wr_chk(logic [4:0] idx, logic [31:0] d, bit dbg, logic [31:0] exp, string tag);
    step(1'b1, idx, d, dbg, idx);
    expect_out(1, exp, tag);
    step(1'b0, 5'd0, 32'h0, 1'b0, idx);
    expect_out(0, exp, tag);
  endtask

  task automatic rd_chk(logic [4:0] idx, logic [31:0] exp, string tag);
    step(1'b0, 5'd0, 32'h0, 1'b0, idx);
    expect_out(0, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; dbg_mode = 1'b0; wr_en = 1'b0;
    wr_idx = '0; wr_data = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(5'd5, 32'h0000_8000, "R1");
    expect_out(2, 32'h0000_8000, "R1");
    rd_chk(5'd0, 32'h0, "R1");
    rd_chk(5'd4, 32'h0, "R1");
    rd_chk(5'd24, 32'h0, "R1");
    rd_chk(5'd29, 32'h0, "R1");
    rd_chk(5'd31, 32'h0, "R1");

    // R2 status masks, R11 export
    wr_chk(5'd5, 32'hFFFF_FFFF, 1'b0, 32'h000F_F3FF, "R2");
    expect_out(2, 32'h000F_F3FF, "R11");
    wr_chk(5'd1, 32'h1234_5678, 1'b0, 32'h0004_5278, "R2");
    wr_chk(5'd3, 32'hABCD_EFFF, 1'b0, 32'h000D_E3FF, "R2");
    wr_chk(5'd5, 32'h0003_0C05, 1'b0, 32'h0003_0005, "R2");
    expect_out(2, 32'h0003_0005, "R11");

    // R3 even addresses
    wr_chk(5'd0, 32'h0000_1235, 1'b0, 32'h0000_1234, "R3");
    wr_chk(5'd2, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, "R3");
    wr_chk(5'd25, 32'h0000_0007, 1'b0, 32'h0000_0006, "R3");

    // R4 cause register locked outside debug
    wr_chk(5'd4, 32'hDEAD_BEEF, 1'b0, 32'h0, "R4");
    wr_chk(5'd4, 32'h0012_0034, 1'b1, 32'h0012_0034, "R4");
    wr_chk(5'd4, 32'h0000_FFFF, 1'b0, 32'h0012_0034, "R4");

    // R5 constants
    wr_chk(5'd6, 32'hFFFF_FFFF, 1'b0, 32'h0000_5346, "R5");
    wr_chk(5'd7, 32'h0, 1'b1, 32'h0000_00E0, "R5");
    wr_chk(5'd30, 32'h0000_0009, 1'b0, 32'h0000_0004, "R5");

    // R6 scratch A
    wr_chk(5'd29, 32'hCAFE_F00D, 1'b0, 32'hCAFE_F00D, "R6");

    // R7 scratch B magnitude
    wr_chk(5'd31, 32'hFFFF_FFF6, 1'b0, 32'h0000_000A, "R7");
    wr_chk(5'd31, 32'h0000_0005, 1'b0, 32'h0000_0005, "R7");
    wr_chk(5'd31, 32'hFFFF_FFF6, 1'b1, 32'hFFFF_FFF6, "R7");

    // R8 cache control
    wr_chk(5'd24, 32'hFFFF_FFFF, 1'b0, 32'h0000_0002, "R8");
    wr_chk(5'd24, 32'hFFFF_FFFD, 1'b0, 32'h0000_0000, "R8");

    // R9 unmapped
    wr_chk(5'd10, 32'h0000_1234, 1'b0, 32'h0, "R9");
    rd_chk(5'd27, 32'h0, "R9");

    // R10 stored value tracks inputs combinationally
    step(1'b0, 5'd0, 32'h0000_0003, 1'b0, 5'd29);
    expect_out(1, 32'h0000_0002, "R10");
    expect_out(0, 32'hCAFE_F00D, "R10");

    // R12 writes gated by enable
    step(1'b0, 5'd29, 32'h0, 1'b1, 5'd29);
    step(1'b0, 5'd5, 32'h0, 1'b0, 5'd29);
    expect_out(0, 32'hCAFE_F00D, "R12");
    step(1'b0, 5'd0, 32'h0, 1'b0, 5'd5);
    expect_out(0, 32'h0003_0005, "R12");
    expect_out(2, 32'h0003_0005, "R12");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule